// File: doc/BRIEF.md
# Copy-Protection VBI Line Insertion Scheduler

This block decides, once per video line, whether a copy-generation management packet goes out on that line and which kind of packet it is: the standard 20-bit word or the longer Type B packet. A line-timing generator outside the block supplies a one-cycle line-start pulse together with the current frame line number and a field flag. The scheduler compares the line number with a fixed insertion line that depends on the selected video format and packet kind. It then issues a registered one-clock insert strobe and a packet-kind flag to a downstream serializer.

Standard-definition output carries only the standard packet, and only on the 60 Hz interlaced format. A 2-bit field-select code picks the fields that carry it. Enhanced- and high-definition formats have one enable for the standard packet and a separate enable for Type B. The interlaced high-definition format has one insertion line in each field, and the line number alone tells the two apart.

Top module: `cgms_line_sched`

## Requirements
- R1: `ins_stb` is high only in the clock that follows a cycle with `line_start` high and matching inputs. It is high for exactly one clock per `line_start` pulse, and never without a preceding `line_start`.
- R2: With `fmt_sel`=0 (SD 60 Hz interlaced), a strobe is issued on line 20 when `field_odd`=1 and `sd_field_sel[0]`=1, and on line 283 when `field_odd`=0 and `sd_field_sel[1]`=1. So code 00 gives none, 01 gives odd fields only, 10 gives even fields only, and 11 gives both.
- R3: With `fmt_sel`=1 (any other SD format), no strobe is issued.
- R4: In SD formats, `std_en` and `typeb_en` have no effect. Only the field-select code gates insertion.
- R5: With `fmt_sel`=2 (525p), the standard packet goes on line 41 and Type B goes on line 40. `field_odd` is ignored.
- R6: With `fmt_sel`=3 (625p), the standard packet goes on line 43, and Type B is never issued.
- R7: With `fmt_sel`=4 (720p), the standard packet goes on line 24 and Type B goes on line 23.
- R8: With `fmt_sel`=5 (1080i), the standard packet goes on lines 19 and 582, and Type B goes on lines 18 and 581, whatever the value of `field_odd`.
- R9: In ED/HD formats, `std_en`=0 suppresses standard packets and `typeb_en`=0 suppresses Type B packets. Each enable affects only its own kind.
- R10: `fmt_sel` values 6 and 7 produce no strobe.
- R11: `pkt_typeb` is 1 together with a Type B strobe. It is 0 with a standard strobe and 0 whenever `ins_stb` is 0.
- R12: While `rst_n` is low, and in the first cycle after release, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| fmt_sel | input | 3 | Video format: 0 SD 60 Hz, 1 other SD, 2 525p, 3 625p, 4 720p, 5 1080i |
| line_num | input | LINE_W | Current frame line number, valid with `line_start` |
| field_odd | input | 1 | 1 in odd fields, 0 in even fields |
| sd_field_sel | input | 2 | SD field-select code: bit 0 enables odd fields, bit 1 enables even fields |
| std_en | input | 1 | ED/HD standard packet enable |
| typeb_en | input | 1 | ED/HD Type B packet enable |
| ins_stb | output | 1 | One-clock insert strobe |
| pkt_typeb | output | 1 | Packet kind with the strobe: 1 for Type B, 0 for standard |

## Verification
Each result arrives one clock after its `line_start` cycle, because the decode is combinational and only the output register lies between input and output. The bench changes inputs on the falling edge, holds `line_start` high across one rising edge, and samples both outputs at the next falling edge. It then lowers `line_start` with every other input unchanged, and samples one clock later to confirm that the strobe has fallen. The sweep covers every format code, both field values, all four field-select codes, all enable combinations, and the line ranges around each insertion line, including line 0.

// File: rtl/cgms_sched_pkg.sv
package cgms_sched_pkg;

   localparam int NUM_SLOTS = 2;   // at most two lines per packet kind per frame
   localparam int SLOT_W    = 10;  // wide enough for the highest insertion line

   localparam logic [2:0] FMT_SD60  = 3'd0;
   localparam logic [2:0] FMT_SDX   = 3'd1;
   localparam logic [2:0] FMT_P525  = 3'd2;
   localparam logic [2:0] FMT_P625  = 3'd3;
   localparam logic [2:0] FMT_P720  = 3'd4;
   localparam logic [2:0] FMT_I1080 = 3'd5;

   // Returns the insertion line for a format, packet kind and slot; 0 = unused slot.
   function automatic logic [SLOT_W-1:0] slot_line(input logic [2:0] fmt,
                                                   input logic       typeb,
                                                   input int         idx);
      logic [SLOT_W-1:0] l0, l1;
      l0 = '0;
      l1 = '0;
      case (fmt)
         FMT_SD60:  if (!typeb) begin l0 = 10'd20;  l1 = 10'd283; end
         FMT_P525:  l0 = typeb ? 10'd40 : 10'd41;
         FMT_P625:  if (!typeb) l0 = 10'd43;
         FMT_P720:  l0 = typeb ? 10'd23 : 10'd24;
         FMT_I1080: begin
            l0 = typeb ? 10'd18  : 10'd19;
            l1 = typeb ? 10'd581 : 10'd582;
         end
         default: ;
      endcase
      return (idx == 0) ? l0 : l1;
   endfunction

endpackage

// File: rtl/cgms_fmt_decode.sv
module cgms_fmt_decode
   import cgms_sched_pkg::*;
#(
   parameter int LINE_W = 11
) (
   input  logic [2:0]                          fmt_sel,
   output logic [NUM_SLOTS-1:0][LINE_W-1:0]    std_slot,
   output logic [NUM_SLOTS-1:0][LINE_W-1:0]    typeb_slot,
   output logic                                is_sd
);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      assign std_slot[i]   = LINE_W'(slot_line(fmt_sel, 1'b0, i));
      assign typeb_slot[i] = LINE_W'(slot_line(fmt_sel, 1'b1, i));
   end

   // SD formats obey the field-select code rather than the ED/HD enables.
   assign is_sd = (fmt_sel == FMT_SD60) || (fmt_sel == FMT_SDX);

endmodule

// File: rtl/cgms_slot_cmp.sv
module cgms_slot_cmp #(
   parameter int LINE_W = 11
) (
   input  logic [LINE_W-1:0] line_num,
   input  logic [LINE_W-1:0] slot,
   output logic              hit
);

   // A zero slot marks "no insertion line", so line 0 never matches.
   assign hit = (slot != '0) && (line_num == slot);

endmodule

// File: rtl/cgms_insert_gate.sv
module cgms_insert_gate
   import cgms_sched_pkg::*;
(
   input  logic [NUM_SLOTS-1:0] std_hit,
   input  logic [NUM_SLOTS-1:0] typeb_hit,
   input  logic                 is_sd,
   input  logic                 field_odd,
   input  logic [1:0]           sd_field_sel,
   input  logic                 std_en,
   input  logic                 typeb_en,
   output logic                 go,
   output logic                 go_typeb
);

   logic sd_go, std_go, b_go;

   // SD: slot 0 belongs to the odd field, slot 1 to the even field.
   assign sd_go  = (std_hit[0] &&  field_odd && sd_field_sel[0]) ||
                   (std_hit[1] && !field_odd && sd_field_sel[1]);
   assign std_go = is_sd ? sd_go : (std_en && (|std_hit));
   assign b_go   = !is_sd && typeb_en && (|typeb_hit);

   assign go       = std_go || b_go;
   assign go_typeb = b_go;

endmodule

// File: rtl/cgms_line_sched.sv
module cgms_line_sched
   import cgms_sched_pkg::*;
#(
   parameter int LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic [2:0]        fmt_sel,
   input  logic [LINE_W-1:0] line_num,
   input  logic              field_odd,
   input  logic [1:0]        sd_field_sel,
   input  logic              std_en,
   input  logic              typeb_en,
   output logic              ins_stb,
   output logic              pkt_typeb
);

   if (LINE_W < SLOT_W) begin : g_bad_width
      $error("LINE_W must hold the highest insertion line");
   end

   logic [NUM_SLOTS-1:0][LINE_W-1:0] std_slot, typeb_slot;
   logic [NUM_SLOTS-1:0]             std_hit, typeb_hit;
   logic                             is_sd, go, go_typeb;

   cgms_fmt_decode #(.LINE_W(LINE_W)) u_dec (
      .fmt_sel    (fmt_sel),
      .std_slot   (std_slot),
      .typeb_slot (typeb_slot),
      .is_sd      (is_sd)
   );

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
      cgms_slot_cmp #(.LINE_W(LINE_W)) u_std (
         .line_num (line_num),
         .slot     (std_slot[i]),
         .hit      (std_hit[i])
      );
      cgms_slot_cmp #(.LINE_W(LINE_W)) u_tb (
         .line_num (line_num),
         .slot     (typeb_slot[i]),
         .hit      (typeb_hit[i])
      );
   end

   cgms_insert_gate u_gate (
      .std_hit      (std_hit),
      .typeb_hit    (typeb_hit),
      .is_sd        (is_sd),
      .field_odd    (field_odd),
      .sd_field_sel (sd_field_sel),
      .std_en       (std_en),
      .typeb_en     (typeb_en),
      .go           (go),
      .go_typeb     (go_typeb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ins_stb   <= 1'b0;
         pkt_typeb <= 1'b0;
      end else begin
         ins_stb   <= line_start && go;
         pkt_typeb <= line_start && go_typeb;
      end
   end

   AST_STB_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> !ins_stb);                                          // R1
   AST_KIND_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_typeb |-> ins_stb);                                             // R11
   AST_HITS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({|std_hit, |typeb_hit}));                                  // R11
   AST_OTHER_SD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && fmt_sel == FMT_SDX) |=> !ins_stb);                   // R3
   AST_625_NO_TYPEB: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && fmt_sel == FMT_P625) |=> !pkt_typeb);                // R6
   AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && fmt_sel > FMT_I1080) |=> !ins_stb);                  // R10
   AST_EDHD_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !is_sd && !std_en && !typeb_en) |=> !ins_stb);       // R9

endmodule

// File: tb/tb_cgms_line_sched.sv
module tb_cgms_line_sched;

   localparam int LINE_W = 11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              line_start = 1'b0;
   logic [2:0]        fmt_sel = '0;
   logic [LINE_W-1:0] line_num = '0;
   logic              field_odd = 1'b0;
   logic [1:0]        sd_field_sel = '0;
   logic              std_en = 1'b0;
   logic              typeb_en = 1'b0;
   logic              ins_stb, pkt_typeb;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   cgms_line_sched #(.LINE_W(LINE_W)) dut (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .fmt_sel(fmt_sel),
      .line_num(line_num), .field_odd(field_odd), .sd_field_sel(sd_field_sel),
      .std_en(std_en), .typeb_en(typeb_en), .ins_stb(ins_stb), .pkt_typeb(pkt_typeb)
   );

   function automatic string req_of(input int fmt);
      case (fmt)
         0: return "R2";
         1: return "R3";
         2: return "R5";
         3: return "R6";
         4: return "R7";
         5: return "R8";
         default: return "R10";
      endcase
   endfunction

   // Expected outputs, written from the requirements.
   task automatic model(input int fmt, input int ln, input int fo, input int sel,
                        input int se, input int te, output bit stb, output bit tb);
      bit s, b;
      s = 0; b = 0;
      case (fmt)
         0: s = (ln == 20 && fo == 1 && (sel & 1) != 0) ||
                (ln == 283 && fo == 0 && (sel & 2) != 0);        // R2, R4: enables unused
         2: begin s = (se != 0) && ln == 41; b = (te != 0) && ln == 40; end
         3: s = (se != 0) && ln == 43;
         4: begin s = (se != 0) && ln == 24; b = (te != 0) && ln == 23; end
         5: begin s = (se != 0) && (ln == 19 || ln == 582);
                  b = (te != 0) && (ln == 18 || ln == 581); end
         default: ;                                                // R3, R10
      endcase
      stb = s || b;
      tb  = b;
   endtask

   task automatic check(input string req, input bit act_s, input bit act_b,
                        input bit exp_s, input bit exp_b);
      n_vec++;
      if (act_s !== exp_s || act_b !== exp_b) begin
         n_bad++;
         $display("FAIL %s: ins_stb/pkt_typeb = %b/%b, expected %b/%b (fmt=%0d line=%0d odd=%b sel=%0d en=%b%b)",
                  req, act_s, act_b, exp_s, exp_b, fmt_sel, line_num, field_odd,
                  sd_field_sel, std_en, typeb_en);
      end
   endtask

   task automatic apply(input int fmt, input int ln, input int fo, input int sel, input int en);
      bit es, eb;
      @(negedge clk);
      fmt_sel      = 3'(fmt);
      line_num     = LINE_W'(ln);
      field_odd    = fo[0];
      sd_field_sel = 2'(sel);
      std_en       = en[0];   // R9: each enable swept on its own
      typeb_en     = en[1];
      line_start   = 1'b1;
      model(fmt, ln, fo, sel, en & 1, en & 2, es, eb);
      @(negedge clk);
      check(req_of(fmt), ins_stb, pkt_typeb, es, eb);
      check("R11", pkt_typeb && !ins_stb, 1'b0, 1'b0, 1'b0);
      line_start = 1'b0;
      @(negedge clk);
      check("R1", ins_stb, pkt_typeb, 1'b0, 1'b0);   // one clock only
   endtask

   initial begin
      @(negedge clk);
      line_start = 1'b1; fmt_sel = 3'd2; line_num = LINE_W'(41); std_en = 1'b1;
      repeat (3) @(negedge clk);
      check("R12", ins_stb, pkt_typeb, 1'b0, 1'b0);   // held in reset
      line_start = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R12", ins_stb, pkt_typeb, 1'b0, 1'b0);   // first cycle after release
      for (int ln = 0; ln < 592; ln++) begin
         if (ln < 64 || (ln >= 280 && ln < 288) || ln >= 576) begin
            for (int fmt = 0; fmt < 8; fmt++)
               for (int fo = 0; fo < 2; fo++)
                  for (int sel = 0; sel < 4; sel++)
                     for (int en = 0; en < 4; en++)
                        apply(fmt, ln, fo, sel, en);
         end
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule